// File: doc/BRIEF.md
# DMA Interrupt Cause Register Bank

This block collects the interrupt causes of a multi-channel DMA controller and merges them into one interrupt request line. Each channel gives a one-cycle pulse when one of its transfers finishes, and the engine gives a separate one-cycle pulse when an error occurs. Each pulse sets a sticky flag. Software reads the flags over a small register bus and clears them by writing ones.

Each channel's completion flag is gated by an enable bit before it reaches the interrupt line. The enable bits are changed through two write-one registers, one that sets bits and one that clears them. Both flags and enables can therefore be changed without a read-modify-write. The error flag is not gated: it always raises the interrupt. The channel count is a parameter, with a maximum of 32. Word bits at or above the channel count have no effect and read as zero.

Top module: `dmairq_regs`

## Requirements
- R1: After reset, the error flag, every completion flag, every enable bit and `irq_out` are 0.
- R2: An `err_pulse` sets the error flag. The flag reads at bit 0 of offset 0x0, and bits 31..1 of that word always read 0.
- R3: A write to offset 0x0 with bit 0 = 1 clears the error flag. With bit 0 = 0, the write leaves the flag unchanged.
- R4: A pulse on `done_pulse[i]` sets completion flag i. The completion flags read at offset 0x4, with channel i at bit i.
- R5: A write to offset 0x4 clears every completion flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R6: A write to offset 0x8 sets every enable bit whose data bit is 1. Data bits that are 0 change nothing. A read of 0x8 returns the enable state, with channel i at bit i.
- R7: A write to offset 0xC clears every enable bit whose data bit is 1. Data bits that are 0 change nothing. A read of 0xC returns the same enable state as 0x8.
- R8: At offsets 0x4, 0x8 and 0xC, bits at or above NCH cannot be set and always read 0.
- R9: If a cause pulse and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R10: `irq_out` is a register. After each clock edge it equals the value that (error flag) OR (any completion flag AND its enable bit) had before that edge.
- R11: Reads from any address other than 0x0, 0x4, 0x8 and 0xC return 0. Writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| done_pulse | input | NCH | Per-channel transfer-completion pulses |
| err_pulse | input | 1 | Error cause pulse |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
Some behaviours are checked by the assertions on every cycle:
- A cause pulse always leaves its flag set on the next cycle, even when a clear hits the same bit.
- Write-one clears and sets take effect on the flags and enables.
- The interrupt line follows the flags one cycle later.
- Bits above the channel count never read as one.

Other behaviours only the bench's scenarios can show:
- Zero bits in a write leave state unchanged.
- The set and clear offsets read back the same enable word.
- Unmapped addresses neither read data nor alter state.
- Long mixed sequences of pulses and writes keep the three words consistent with each other.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OFS_ERR   = 'h0;
  localparam int unsigned OFS_DONE  = 'h4;
  localparam int unsigned OFS_ENSET = 'h8;
  localparam int unsigned OFS_ENCLR = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ERR,
    SEL_DONE,
    SEL_ENSET,
    SEL_ENCLR
  } reg_sel_e;

  // Mask of implemented channel bits within a 32-bit word
  function automatic logic [WORD_W-1:0] chan_mask(input int unsigned nch);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i < nch) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Next value of a sticky flag: clears apply first, new causes win
  function automatic logic flag_next(input logic cur, input logic cause,
                                     input logic clr);
    return cause | (cur & ~clr);
  endfunction

  // Combined request from the error flag and the gated pending summary
  function automatic logic irq_next(input logic err, input logic any_pending);
    return err | any_pending;
  endfunction

endpackage

// File: rtl/dmairq_flags.sv
module dmairq_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags
);
  import dmairq_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= flag_next(q, cause[i], clr[i]);
    end
    assign flags[i] = q;
  end

endmodule

// File: rtl/dmairq_enables.sv
module dmairq_enables #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] en
);

  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en = en_q;

endmodule

// File: rtl/dmairq_irq_merge.sv
module dmairq_irq_merge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         err_flag,
  input  logic [W-1:0] done_flags,
  input  logic [W-1:0] en,
  output logic         pending_any,
  output logic         irq
);
  import dmairq_pkg::*;

  logic irq_q;

  assign pending_any = |(done_flags & en);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next(err_flag, pending_any);
  end

  assign irq = irq_q;

endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    done_pulse,
  input  logic              err_pulse,
  output logic              irq_out
);
  import dmairq_pkg::*;

  localparam logic [31:0] MASK = chan_mask(NCH);

  reg_sel_e         sel;
  logic             wr_err, wr_done, wr_enset, wr_enclr;
  logic [NCH-1:0]   done_clr, en_set, en_clr;
  logic [NCH-1:0]   done_flag, en_q;
  logic             err_flag;
  logic             pending_any;
  logic [31:0]      done_word, en_word;

  // Address decode
  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_ERR))   sel = SEL_ERR;
    else if (bus_addr == ADDR_W'(OFS_DONE))  sel = SEL_DONE;
    else if (bus_addr == ADDR_W'(OFS_ENSET)) sel = SEL_ENSET;
    else if (bus_addr == ADDR_W'(OFS_ENCLR)) sel = SEL_ENCLR;
    else                                     sel = SEL_NONE;
  end

  assign wr_err   = bus_wr && (sel == SEL_ERR);
  assign wr_done  = bus_wr && (sel == SEL_DONE);
  assign wr_enset = bus_wr && (sel == SEL_ENSET);
  assign wr_enclr = bus_wr && (sel == SEL_ENCLR);

  assign done_clr = wr_done  ? bus_wdata[NCH-1:0] : '0;
  assign en_set   = wr_enset ? bus_wdata[NCH-1:0] : '0;
  assign en_clr   = wr_enclr ? bus_wdata[NCH-1:0] : '0;

  dmairq_flags #(.W(1)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .cause (err_pulse),
    .clr   (wr_err & bus_wdata[0]),
    .flags (err_flag)
  );

  dmairq_flags #(.W(NCH)) u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .cause (done_pulse),
    .clr   (done_clr),
    .flags (done_flag)
  );

  dmairq_enables #(.W(NCH)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (en_set),
    .clr_bits (en_clr),
    .en       (en_q)
  );

  dmairq_irq_merge #(.W(NCH)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_flag    (err_flag),
    .done_flags  (done_flag),
    .en          (en_q),
    .pending_any (pending_any),
    .irq         (irq_out)
  );

  assign done_word = 32'(done_flag) & MASK;
  assign en_word   = 32'(en_q) & MASK;

  // Read mux
  always_comb begin
    unique case (sel)
      SEL_ERR:            bus_rdata = {31'b0, err_flag};
      SEL_DONE:           bus_rdata = done_word;
      SEL_ENSET,
      SEL_ENCLR:          bus_rdata = en_word;
      default:            bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NCH-1:0]    done_pulse,
  input logic              err_pulse,
  input logic              irq_out,
  input logic [NCH-1:0]    done_flag,
  input logic [NCH-1:0]    en_q,
  input logic              err_flag,
  input logic              pending_any
);
  import dmairq_pkg::*;

  localparam logic [31:0] MASK = chan_mask(NCH);

  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> err_flag);

  // R9
  done_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_pulse) |=> ((done_flag & $past(done_pulse)) == $past(done_pulse)));

  // R3
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ERR) && bus_wdata[0] && !err_pulse)
      |=> !err_flag);

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_DONE))
      |=> ((done_flag & $past(bus_wdata[NCH-1:0] & ~done_pulse)) == '0));

  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENSET))
      |=> ((en_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // R7
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ENCLR))
      |=> ((en_q & $past(bus_wdata[NCH-1:0])) == '0));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == $past(err_flag | pending_any)));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~MASK & ~32'h1) == '0);

endmodule

bind dmairq_regs dmairq_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .done_pulse  (done_pulse),
  .err_pulse   (err_pulse),
  .irq_out     (irq_out),
  .done_flag   (done_flag),
  .en_q        (en_q),
  .err_flag    (err_flag),
  .pending_any (pending_any)
);

// File: tb/tb_dmairq_regs.sv
`timescale 1ns/1ps
module tb_dmairq_regs;
  localparam int NCH = 6;
  localparam logic [31:0] M = (32'h1 << NCH) - 1;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] done_pulse = 0;
  logic        err_pulse = 0;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  logic        merr = 0;
  logic [NCH-1:0] mdone = 0, men = 0;

  always #2 clk = ~clk;

  dmairq_regs #(.NCH(NCH), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .irq_out(irq_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  // One clock cycle of stimulus; model updated arithmetically
  task automatic step(input logic [NCH-1:0] p, input logic ep, input logic wr,
                      input logic [3:0] a, input logic [31:0] d);
    logic exp_irq;
    @(negedge clk);
    done_pulse = p; err_pulse = ep; bus_wr = wr; bus_addr = a; bus_wdata = d;
    exp_irq = merr | (|(mdone & men));
    if (wr && a == 4'h0 && d[0]) merr = 0;
    if (ep) merr = 1;
    if (wr && a == 4'h4) mdone = mdone & ~d[NCH-1:0];
    mdone = mdone | p;
    if (wr && a == 4'h8) men = men | d[NCH-1:0];
    if (wr && a == 4'hC) men = men & ~d[NCH-1:0];
    @(posedge clk);
    #1;
    done_pulse = 0; err_pulse = 0; bus_wr = 0;
    check("R10 irq", {31'b0, irq_out}, {31'b0, exp_irq});
  endtask

  task automatic full_cmp(input string tag);
    rd_chk({tag, " err"}, 4'h0, {31'b0, merr});
    rd_chk({tag, " done"}, 4'h4, 32'(mdone));
    rd_chk({tag, " enset"}, 4'h8, 32'(men));
    rd_chk({tag, " enclr"}, 4'hC, 32'(men));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    full_cmp("R1");
    check("R1 irq", {31'b0, irq_out}, 0);

    // R4/R5 per-channel sweep
    for (int i = 0; i < NCH; i++) begin
      step(NCH'(1 << i), 0, 0, 4'h4, 0);
      rd_chk("R4 set", 4'h4, 32'h1 << i);
      step(0, 0, 1, 4'h4, ~(32'h1 << i));
      rd_chk("R5 zero keeps", 4'h4, 32'h1 << i);
      step(0, 0, 1, 4'h4, 32'h1 << i);
      rd_chk("R5 clear", 4'h4, 0);
    end

    // R2/R3 error flag
    step(0, 1, 0, 4'h0, 0);
    rd_chk("R2 set", 4'h0, 1);
    step(0, 0, 1, 4'h0, 32'hFFFF_FFFE);
    rd_chk("R3 zero keeps", 4'h0, 1);
    step(0, 0, 0, 4'h0, 0);
    check("R10 err irq", {31'b0, irq_out}, 1);
    step(0, 0, 1, 4'h0, 1);
    rd_chk("R3 clear", 4'h0, 0);

    // R6/R7/R8 enables
    step(0, 0, 1, 4'h8, 32'hFFFF_FFFF);
    rd_chk("R6 set", 4'h8, M);
    rd_chk("R7 read", 4'hC, M);
    step(0, 0, 1, 4'hC, 32'h5);
    rd_chk("R7 clear", 4'h8, M & ~32'h5);
    step(0, 0, 1, 4'h8, 0);
    rd_chk("R6 zero keeps", 4'hC, M & ~32'h5);
    step(0, 0, 1, 4'hC, 32'hFFFF_FFC0);
    rd_chk("R8 high clear none", 4'h8, M & ~32'h5);
    step(0, 0, 1, 4'hC, 32'hFFFF_FFFF);
    step(0, 0, 1, 4'h8, 32'hFFFF_FFC0);
    rd_chk("R8 high set none", 4'h8, 0);

    // R10 gating: flag without enable
    step(6'h04, 0, 0, 4'h0, 0);
    step(0, 0, 0, 4'h0, 0);
    check("R10 gated off", {31'b0, irq_out}, 0);
    step(0, 0, 1, 4'h8, 32'h4);
    step(0, 0, 0, 4'h0, 0);
    check("R10 gated on", {31'b0, irq_out}, 1);

    // R9 set wins over clear
    step(6'h04, 0, 1, 4'h4, 32'h4);
    rd_chk("R9 done", 4'h4, 32'h4);
    step(0, 1, 1, 4'h0, 1);
    rd_chk("R9 err", 4'h0, 1);

    // R11 unmapped addresses
    step(6'h3F, 0, 1, 4'h8, 32'h3F);
    for (int a = 0; a < 16; a++) begin
      if (a % 4 != 0) begin
        rd_chk("R11 read", 4'(a), 0);
        step(0, 0, 1, 4'(a), 32'hFFFF_FFFF);
        full_cmp("R11 write");
      end
    end

    // Mixed sequence
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[5:0] & {6{lfsr[6]}}, lfsr[7] & lfsr[8], lfsr[9],
           {lfsr[12:11], 2'b00}, {lfsr[31:14], lfsr[13:0]});
      if (n % 8 == 0) full_cmp("R4 R5 R6 R7 mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule